// File: doc/BRIEF.md
# Receive Character Buffer with Fill-Level Interrupt

This block sits on the receive side of a serial port. It sits between the character deserializer and the register read path. Each incoming character is stored as an 11-bit entry: the data byte is in bits 7:0 and receive status is in bits 10:8. A bus read takes the entries back in the order they arrived. A separate line-break strobe stores a dedicated entry in which bit 10 is set and the data is zero.

The buffer keeps a read pointer and an occupancy count. It drives empty and full flags and tells the deserializer whether one more character can be taken. The buffer has two modes. With queuing enabled it holds up to 16 entries. With queuing disabled it behaves as a single holding slot.

A receive interrupt request is raised when a push brings the occupancy up to a programmed threshold. It is dropped when a read brings the occupancy down to one below that threshold. The threshold is taken from a level-configuration field when a configuration strobe is applied.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the buffer has occupancy 0 and read pointer 0, with `empty`=1, `full`=0, `rx_irq`=0 and `can_accept`=1.
- R2: Entries are returned in arrival order from a 16-slot circular store. The read pointer wraps from slot 15 to slot 0. `rd_data` always shows the entry at the read pointer.
- R3: `can_accept` is high while occupancy is below 16 when `fifo_en`=1, and while occupancy is 0 when `fifo_en`=0. A push offered while `can_accept` is low is discarded.
- R4: `empty` clears on any accepted push. It sets when a read brings occupancy to 0.
- R5: `full` sets after an accepted push that leaves occupancy at 16, or after any accepted push while `fifo_en`=0. Any read clears `full`.
- R6: `rx_irq` sets when an accepted push leaves the occupancy equal to the threshold.
- R7: `rx_irq` clears when a read leaves the occupancy equal to the threshold minus one.
- R8: On a `cfg_wr` strobe the threshold is loaded with `{level_cfg[5:3],2'b00}` if `fifo_en`=1, and with 1 if `fifo_en`=0. The threshold does not change at any other time, and reset loads 1.
- R9: A `push_break` pulse stores the value 0x400 (bit 10 set, data zero). It has priority over `push_data` when both are offered in the same cycle.
- R10: A read while empty leaves the pointer and occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single slot |
| level_cfg | input | 6 | Level-configuration field feeding the threshold |
| cfg_wr | input | 1 | Strobe that reloads the threshold |
| push_valid | input | 1 | Offer `push_data` as a new entry |
| push_data | input | 11 | Status bits 10:8 and data byte 7:0 |
| push_break | input | 1 | Offer a line-break entry (0x400) |
| pop | input | 1 | Read strobe: consume the entry at the pointer |
| rd_data | output | 11 | Entry at the read pointer |
| can_accept | output | 1 | Another entry may be pushed |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | No further entry will be accepted |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The main function is tested in three ways.

- A climb to a threshold of 8 followed by alternating reads and pushes around it. This shows whether the interrupt sets exactly at the threshold and clears exactly at one below it, rather than at some other level.
- A fill to 16 followed by a rejected push and a full drain, with the total count crossing slot 15. This separates correct wrap-around and discard from lost or reordered entries.
- Single-slot mode and threshold reloads with and without the strobe. These separate the live mode input from the sampled threshold, and a break pushed in the middle of the sequence checks its special value.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ENTRY_W   = 11;
    localparam int BREAK_BIT = 10;

    function automatic logic [ENTRY_W-1:0] break_entry();
        logic [ENTRY_W-1:0] v;
        v = '0;
        v[BREAK_BIT] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH   = 16,
    parameter int WIDTH   = 11,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rxf_thresh.sv
module rxf_thresh #(
    parameter int LVL_W   = 6,
    parameter int THR_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level_cfg,
    output logic [THR_W-1:0] thr
);
    logic [THR_W-1:0] thr_d, thr_q;

    always_comb begin
        thr_d = thr_q;
        if (cfg_wr) begin
            if (fifo_en)
                thr_d = THR_W'({level_cfg[LVL_W-1:LVL_W-3], 2'b00});
            else
                thr_d = THR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= THR_W'(1);
        else        thr_q <= thr_d;
    end

    assign thr = thr_q;
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
    parameter int DEPTH   = 16,
    parameter int LVL_W   = 6,
    localparam int WIDTH  = rxf_pkg::ENTRY_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int THR_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level_cfg,
    input  logic             cfg_wr,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             push_break,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             can_accept,
    output logic             empty,
    output logic             full,
    output logic             rx_irq
);
    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             empty;
        logic             full;
        logic             irq;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [THR_W-1:0] thr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [WIDTH-1:0] wr_data;
    logic             push_any;

    rxf_thresh #(.LVL_W(LVL_W), .THR_W(THR_W)) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .fifo_en   (fifo_en),
        .level_cfg (level_cfg),
        .thr       (thr)
    );

    rxf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ctl_q.rd_ptr),
        .rd_data (rd_data)
    );

    assign push_any   = push_valid || push_break;
    assign can_accept = fifo_en ? (ctl_q.count < CNT_W'(DEPTH))
                                : (ctl_q.count == '0);

    always_comb begin
        ctl_d   = ctl_q;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_data = push_break ? rxf_pkg::break_entry() : push_data;

        // A read in the same cycle is applied before the push.
        if (pop) begin
            ctl_d.full = 1'b0;
            if (ctl_d.count != '0) begin
                ctl_d.rd_ptr = ctl_d.rd_ptr + PTR_W'(1);
                ctl_d.count  = ctl_d.count - CNT_W'(1);
            end
            if (ctl_d.count == '0)
                ctl_d.empty = 1'b1;
            if (({1'b0, ctl_d.count} + (CNT_W+1)'(1)) == (CNT_W+1)'(thr))
                ctl_d.irq = 1'b0;
        end

        if (push_any && can_accept) begin
            wr_en       = 1'b1;
            wr_idx      = ctl_d.rd_ptr + ctl_d.count[PTR_W-1:0];
            ctl_d.count = ctl_d.count + CNT_W'(1);
            ctl_d.empty = 1'b0;
            if (!fifo_en || ctl_d.count == CNT_W'(DEPTH))
                ctl_d.full = 1'b1;
            if ({1'b0, ctl_d.count} == (CNT_W+1)'(thr))
                ctl_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.rd_ptr <= '0;
            ctl_q.count  <= '0;
            ctl_q.empty  <= 1'b1;
            ctl_q.full   <= 1'b0;
            ctl_q.irq    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign empty  = ctl_q.empty;
    assign full   = ctl_q.full;
    assign rx_irq = ctl_q.irq;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_break,
    input logic             pop,
    input logic             can_accept,
    input logic             empty,
    input logic             full,
    input logic             rx_irq,
    input logic [CNT_W-1:0] occ
);
    logic push_any;
    assign push_any = push_valid || push_break;

    assert_empty_tracks_occ_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (occ == '0));

    assert_not_empty_and_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    assert_blocked_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_any && !can_accept && !pop) |=> $stable(occ));

    assert_push_grows_occ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_any && can_accept && !pop) |=> (occ == $past(occ) + CNT_W'(1)));

    assert_empty_read_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push_any) |=> (occ == '0));

    assert_irq_rises_on_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(push_any));

    assert_irq_falls_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(pop));
endmodule

bind rx_char_fifo rxf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_break (push_break),
    .pop        (pop),
    .can_accept (can_accept),
    .empty      (empty),
    .full       (full),
    .rx_irq     (rx_irq),
    .occ        (ctl_q.count)
);

// File: tb/rx_char_fifo_tb.sv
`timescale 1ns/100ps
module rx_char_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1;
    logic [5:0]  level_cfg = '0;
    logic        cfg_wr = 1'b0;
    logic        push_valid = 1'b0;
    logic [10:0] push_data = '0;
    logic        push_break = 1'b0;
    logic        pop = 1'b0;
    logic [10:0] rd_data;
    logic        can_accept, empty, full, rx_irq;

    int n_checks = 0;
    int n_fails  = 0;
    logic [10:0] model_q[$];

    always #2.5 clk = ~clk;

    rx_char_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .level_cfg(level_cfg),
        .cfg_wr(cfg_wr), .push_valid(push_valid), .push_data(push_data),
        .push_break(push_break), .pop(pop), .rd_data(rd_data),
        .can_accept(can_accept), .empty(empty), .full(full), .rx_irq(rx_irq)
    );

    // Vector: op[15:14] (0 push, 1 read, 2 break), data[13:3], irq, empty, full
    localparam logic [15:0] VEC [12] = '{
        {2'd0, 11'h001, 3'b000}, {2'd0, 11'h002, 3'b000},
        {2'd0, 11'h003, 3'b000}, {2'd0, 11'h004, 3'b000},
        {2'd0, 11'h005, 3'b000}, {2'd0, 11'h006, 3'b000},
        {2'd0, 11'h007, 3'b000}, {2'd0, 11'h008, 3'b100},
        {2'd1, 11'h000, 3'b000}, {2'd0, 11'h009, 3'b100},
        {2'd1, 11'h000, 3'b000}, {2'd2, 11'h000, 3'b100}
    };

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; outputs settle before the next one.
    task automatic step(bit pu, bit br, bit po, logic [10:0] d);
        push_valid = pu; push_break = br; pop = po; push_data = d;
        @(negedge clk);
        push_valid = 0; push_break = 0; pop = 0; push_data = '0;
    endtask

    task automatic do_push(logic [10:0] d, bit accept_exp);
        step(1, 0, 0, d);
        if (accept_exp) model_q.push_back(d);
    endtask

    task automatic do_pop();
        step(0, 0, 1, '0);
        if (model_q.size() > 0) void'(model_q.pop_front());
    endtask

    task automatic set_cfg(bit en, logic [5:0] lvl);
        fifo_en = en; level_cfg = lvl; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R1 can_accept", can_accept, 1);

        // threshold {3'b010,2'b00} = 8 (R8)
        set_cfg(1, 6'b010_000);
        foreach (VEC[i]) begin
            logic [1:0] op;
            op = VEC[i][15:14];
            if (op == 2'd0) do_push(VEC[i][13:3], 1);
            else if (op == 2'd1) do_pop();
            else begin
                step(0, 1, 0, 11'h0FF);
                model_q.push_back(11'h400);
            end
            chk("R6/R7 irq at threshold 8", rx_irq, VEC[i][2]);
            chk("R4 empty", empty, VEC[i][1]);
            chk("R5 full", full, VEC[i][0]);
            chk("R2 head", rd_data, model_q[0]);
        end

        // Fill to 16, then offer one more: it must be discarded (R3)
        for (int k = 0; k < 8; k++) do_push(11'h010 + 11'(k), 1);
        chk("R5 full at 16", full, 1);
        chk("R3 can_accept low at 16", can_accept, 0);
        do_push(11'h0EE, 0);
        chk("R3 still full", full, 1);
        chk("R6 irq unchanged above threshold", rx_irq, 1);

        // Drain; arrival order across the slot 15 wrap (R2), break entry (R9)
        for (int k = 0; k < 16; k++) begin
            if (model_q.size() > 0) begin
                if (model_q[0] == 11'h400) chk("R9 break entry", rd_data, 11'h400);
                else chk("R2 drain order", rd_data, model_q[0]);
            end
            do_pop();
            if (k == 0) chk("R5 read clears full", full, 0);
            if (k == 8) chk("R7 irq clears at 7", rx_irq, 0);
        end
        chk("R4 empty after drain", empty, 1);
        chk("R7 irq low after drain", rx_irq, 0);

        // Read while empty, then push: the new entry must be at the head with occupancy 1 (R10)
        do_pop();
        chk("R10 still empty", empty, 1);
        do_push(11'h155, 1);
        chk("R10 head after empty read", rd_data, 11'h155);
        do_pop();
        chk("R10 single entry drained", empty, 1);

        // Break and data offered together: the break wins (R9)
        step(1, 1, 0, 11'h0AA);
        chk("R9 break priority", rd_data, 11'h400);
        chk("R9 one entry stored", empty, 0);
        do_pop();
        chk("R9 only one entry", empty, 1);

        // Single-slot mode, threshold 1 (R8, R3, R5)
        set_cfg(0, 6'b111_111);
        do_push(11'h022, 1);
        chk("R5 full in single-slot mode", full, 1);
        chk("R8 irq threshold 1", rx_irq, 1);
        chk("R3 can_accept at 1 in single-slot mode", can_accept, 0);
        do_push(11'h033, 0);
        chk("R3 second push discarded", rd_data, 11'h022);
        do_pop();
        chk("R7 irq clears at 0", rx_irq, 0);
        chk("R4 empty after single read", empty, 1);
        chk("R5 full cleared", full, 0);

        // Level change without the strobe: threshold stays 1 (R8)
        fifo_en = 1; level_cfg = 6'b111_111;
        @(negedge clk);
        do_push(11'h044, 1);
        chk("R8 no reload without strobe", rx_irq, 1);
        do_pop();

        // Reload to threshold {3'b001,2'b00} = 4
        set_cfg(1, 6'b001_000);
        for (int k = 0; k < 3; k++) do_push(11'h060 + 11'(k), 1);
        chk("R8 below threshold 4", rx_irq, 0);
        do_push(11'h063, 1);
        chk("R8 at threshold 4", rx_irq, 1);
        chk("R2 head after reload", rd_data, model_q[0]);

        // Reset mid-stream returns to the initial state (R1)
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 empty after reset", empty, 1);
        chk("R1 irq after reset", rx_irq, 0);
        chk("R1 full after reset", full, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule